// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Decoder

This block is the control front end of a 1M x 16 asynchronous DRAM that has one column strobe per byte lane. All active-low strobes (row strobe, the lane column strobes, write enable, output enable) and the 10-bit multiplexed address are brought into a fast system clock domain through a parameterised synchroniser. The block then detects strobe edges and classifies the ongoing access. The classes are standby, read, early write, read-write, row-strobe-only refresh, column-before-row refresh, and hidden refresh.

The lane strobes are OR-merged into one internal column strobe. That strobe becomes active when the first lane strobe falls and stays active until the last one rises. Each lane strobe also gates its own byte lane. For every lane the block outputs a registered data-drive enable and a write enable. It also outputs the latched row and column addresses and a 3-bit cycle-type code. For refresh cycles that start with a column strobe already low, the row comes from an internal wrapping counter and the external address is ignored. The storage array sits outside the block.

Top module: `dram_strobe_decoder`

## Requirements
- R1: While reset is held and directly after it, cyc_type is 0 (standby), lane_oe and lane_we are 0, and row_addr and col_addr are 0.
- R2: The merged column strobe is active while any cas_n bit is low. col_addr is taken when the first lane strobe falls and is not reloaded when a second lane strobe falls later. The cycle does not return to standby until every cas_n bit and ras_n are high.
- R3: On a ras_n fall with every cas_n high, row_addr takes addr. On a merged column-strobe fall with ras_n low, during a row-only, read, write or read-write cycle, col_addr takes addr and cyc_type is set by we_n.
- R4: A column-strobe fall with we_n high gives cyc_type 1 (read). lane_oe bit i (bit 0 = data 7:0, bit 1 = data 15:8) is 1 only while cas_n[i] is low, oe_n is low and we_n is high, so data starts at the later of the column-strobe fall and the oe_n fall.
- R5: A column-strobe fall with we_n low gives cyc_type 2 (early write). lane_we bit i is 1 while ras_n is low, cas_n[i] is low and we_n is low.
- R6: A we_n fall during a read with the column strobe active gives cyc_type 3 (read-write). lane_we then follows the low lane strobes, and lane_oe is 0 while we_n is low.
- R7: A ras_n fall with every cas_n high gives cyc_type 4 (row-only refresh), row_addr takes addr, and lane_oe and lane_we stay 0.
- R8: A ras_n fall with any cas_n low that does not follow a read gives cyc_type 5 (column-before-row refresh). row_addr takes the refresh counter, and the counter then increments by one, starting at 0 and wrapping. addr is ignored, and lane_oe and lane_we stay 0.
- R9: A ras_n high-then-low pulse while the column strobe stays low after a read gives cyc_type 6 (hidden refresh). row_addr takes the refresh counter, which then increments, and lane_oe keeps driving the read lanes.
- R10: When ras_n and every cas_n are high, cyc_type returns to 0 and every enable is 0. A column-strobe fall with ras_n high starts no access.
- R11: With SYNC_STAGES = S, a change sampled at clock edge k shows on the outputs after edge k+S.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Column strobe per byte lane, active low, bit 0 = lower byte |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| cyc_type | output | 3 | Cycle-type code (0..6) |
| lane_oe | output | LANES | Per-lane data drive enable |
| lane_we | output | LANES | Per-lane write enable |
| row_addr | output | ADDR_W | Latched row address |
| col_addr | output | ADDR_W | Latched column address |

## Verification
A wrong cycle class shows at the ports S+1 clocks after the edge that caused it. It shows as a changed cyc_type code and, most visibly, as a lane enable that is on when it should be off. An example is drive left on during a refresh, or a write that lands in the wrong byte of the bench memory. A wrong column capture or a wrong refresh-counter step only surfaces as a wrong col_addr or row_addr value. The error in the stored data then appears at the next readback of that word. A lost edge (for example, a second lane strobe reloading the column) appears on the very next compare, because the bench's reference model tracks the same inputs every clock.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;
   typedef enum logic [2:0] {
      CYC_IDLE   = 3'd0,
      CYC_READ   = 3'd1,
      CYC_WRITE  = 3'd2,
      CYC_RMW    = 3'd3,
      CYC_ROWREF = 3'd4,
      CYC_CBR    = 3'd5,
      CYC_HIDDEN = 3'd6
   } cyc_e;
endpackage

// File: rtl/dram_strobe_sync.sv
module dram_strobe_sync #(
   parameter int LANES       = 2,
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic [LANES-1:0]  cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              ras_act,
   output logic [LANES-1:0]  cas_act,
   output logic              we_act,
   output logic              oe_act,
   output logic [ADDR_W-1:0] addr_s,
   output logic              ras_prev,
   output logic              cas_any_prev,
   output logic              we_prev
);
   localparam int W = LANES + 3 + ADDR_W;
   localparam logic [W-1:0] IDLE_WORD = {{(LANES+3){1'b1}}, {ADDR_W{1'b0}}};

   logic [W-1:0] stage_q [SYNC_STAGES];
   logic [W-1:0] tail;
   logic [W-1:0] prev_q;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[g] <= IDLE_WORD;
               else        stage_q[g] <= {ras_n, we_n, oe_n, cas_n, addr};
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[g] <= IDLE_WORD;
               else        stage_q[g] <= stage_q[g-1];
         end
      end
   endgenerate

   assign tail = stage_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= IDLE_WORD;
      else        prev_q <= tail;

   assign ras_act      = ~tail[W-1];
   assign we_act       = ~tail[W-2];
   assign oe_act       = ~tail[W-3];
   assign cas_act      = ~tail[ADDR_W +: LANES];
   assign addr_s       = tail[ADDR_W-1:0];
   assign ras_prev     = ~prev_q[W-1];
   assign we_prev      = ~prev_q[W-2];
   assign cas_any_prev = ~(&prev_q[ADDR_W +: LANES]);
endmodule

// File: rtl/dram_cycle_fsm.sv
module dram_cycle_fsm
   import dram_strobe_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_act,
   input  logic [LANES-1:0]  cas_act,
   input  logic              we_act,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic              ras_prev,
   input  logic              cas_any_prev,
   input  logic              we_prev,
   output cyc_e              mode_nxt,
   output cyc_e              mode_q,
   output logic [ADDR_W-1:0] row_q,
   output logic [ADDR_W-1:0] col_q
);
   logic              cas_any, ras_fall, cas_fall, we_fall;
   logic              row_ext_ld, row_cnt_ld, col_ld;
   logic [ADDR_W-1:0] ref_cnt_q;

   assign cas_any  = |cas_act;
   assign ras_fall = ras_act & ~ras_prev;
   assign cas_fall = cas_any & ~cas_any_prev;
   assign we_fall  = we_act & ~we_prev;

   always_comb begin
      mode_nxt   = mode_q;
      row_ext_ld = 1'b0;
      row_cnt_ld = 1'b0;
      col_ld     = 1'b0;
      if (!ras_act && !cas_any) begin
         mode_nxt = CYC_IDLE;
      end else if (ras_fall) begin
         if (cas_any) begin
            row_cnt_ld = 1'b1;
            mode_nxt   = (mode_q == CYC_READ || mode_q == CYC_HIDDEN) ? CYC_HIDDEN : CYC_CBR;
         end else begin
            row_ext_ld = 1'b1;
            mode_nxt   = CYC_ROWREF;
         end
      end else if (cas_fall && ras_act &&
                   (mode_q inside {CYC_ROWREF, CYC_READ, CYC_WRITE, CYC_RMW})) begin
         col_ld   = 1'b1;
         mode_nxt = we_act ? CYC_WRITE : CYC_READ;
      end else if (we_fall && ras_act && cas_any && mode_q == CYC_READ) begin
         mode_nxt = CYC_RMW;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= CYC_IDLE;
         row_q     <= '0;
         col_q     <= '0;
         ref_cnt_q <= '0;
      end else begin
         mode_q <= mode_nxt;
         if (row_ext_ld) row_q <= addr_s;
         if (row_cnt_ld) begin
            row_q     <= ref_cnt_q;
            ref_cnt_q <= ref_cnt_q + 1'b1;
         end
         if (col_ld) col_q <= addr_s;
      end
   end
endmodule

// File: rtl/dram_lane_gate.sv
module dram_lane_gate
   import dram_strobe_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cyc_e             mode_nxt,
   input  logic             ras_act,
   input  logic [LANES-1:0] cas_act,
   input  logic             we_act,
   input  logic             oe_act,
   output logic [LANES-1:0] lane_oe,
   output logic [LANES-1:0] lane_we
);
   logic rd_mode, wr_mode;

   assign rd_mode = (mode_nxt == CYC_READ)  || (mode_nxt == CYC_HIDDEN);
   assign wr_mode = (mode_nxt == CYC_WRITE) || (mode_nxt == CYC_RMW);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_oe[i] <= 1'b0;
               lane_we[i] <= 1'b0;
            end else begin
               lane_oe[i] <= rd_mode && cas_act[i] && oe_act && !we_act;
               lane_we[i] <= wr_mode && cas_act[i] && ras_act && we_act;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
   import dram_strobe_pkg::*;
#(
   parameter int LANES       = 2,
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic [LANES-1:0]  cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [2:0]        cyc_type,
   output logic [LANES-1:0]  lane_oe,
   output logic [LANES-1:0]  lane_we,
   output logic [ADDR_W-1:0] row_addr,
   output logic [ADDR_W-1:0] col_addr
);
   generate
      if (LANES < 1)       begin : g_bad_lanes  $error("LANES must be at least 1");       end
      if (ADDR_W < 2)      begin : g_bad_addr   $error("ADDR_W must be at least 2");      end
      if (SYNC_STAGES < 1) begin : g_bad_sync   $error("SYNC_STAGES must be at least 1"); end
   endgenerate

   logic              ras_act, we_act, oe_act;
   logic [LANES-1:0]  cas_act;
   logic [ADDR_W-1:0] addr_s;
   logic              ras_prev, cas_any_prev, we_prev;
   cyc_e              mode_nxt, mode_q;

   dram_strobe_sync #(.LANES(LANES), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .ras_n, .cas_n, .we_n, .oe_n, .addr,
      .ras_act, .cas_act, .we_act, .oe_act, .addr_s,
      .ras_prev, .cas_any_prev, .we_prev
   );

   dram_cycle_fsm #(.LANES(LANES), .ADDR_W(ADDR_W)) u_fsm (
      .clk, .rst_n, .ras_act, .cas_act, .we_act, .addr_s,
      .ras_prev, .cas_any_prev, .we_prev,
      .mode_nxt, .mode_q, .row_q(row_addr), .col_q(col_addr)
   );

   dram_lane_gate #(.LANES(LANES)) u_lanes (
      .clk, .rst_n, .mode_nxt, .ras_act, .cas_act, .we_act, .oe_act,
      .lane_oe, .lane_we
   );

   assign cyc_type = mode_q;
endmodule

// File: rtl/dram_strobe_decoder_chk.sv
module dram_strobe_decoder_chk #(
   parameter int LANES  = 2,
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cyc_type,
   input logic [LANES-1:0]  lane_oe,
   input logic [LANES-1:0]  lane_we,
   input logic [ADDR_W-1:0] row_addr,
   input logic [ADDR_W-1:0] col_addr
);
   assert_lane_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_oe & lane_we) == '0);

   assert_read_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_oe) |-> (cyc_type == 3'd1 || cyc_type == 3'd6));

   assert_write_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_we) |-> (cyc_type == 3'd2 || cyc_type == 3'd3));

   assert_refresh_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == 3'd4 || cyc_type == 3'd5) |-> (lane_oe == '0 && lane_we == '0));

   assert_standby_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == 3'd0) |-> (lane_oe == '0 && lane_we == '0));

   assert_col_on_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(col_addr) |-> (cyc_type == 3'd1 || cyc_type == 3'd2));

   assert_row_on_ras_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_addr) |-> (cyc_type >= 3'd4 && cyc_type <= 3'd6));
endmodule

bind dram_strobe_decoder dram_strobe_decoder_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .lane_oe(lane_oe),
   .lane_we(lane_we), .row_addr(row_addr), .col_addr(col_addr)
);

// File: tb/dram_strobe_decoder_bench.sv
module dram_strobe_decoder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 2;
   localparam int AW    = 10;
   localparam int S     = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ras_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [1:0]    cas_n = 2'b11;
   logic [AW-1:0] addr = '0;
   logic [2:0]    cyc_type;
   logic [1:0]    lane_oe, lane_we;
   logic [AW-1:0] row_addr, col_addr;
   logic [15:0]   wdata = '0;
   logic [15:0]   mem [256];

   int checks = 0, errors = 0;
   string phase = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_strobe_decoder #(.LANES(LANES), .ADDR_W(AW), .SYNC_STAGES(S)) u_dram_strobe_decoder (
      .clk, .rst_n, .ras_n, .cas_n, .we_n, .oe_n, .addr,
      .cyc_type, .lane_oe, .lane_we, .row_addr, .col_addr
   );

   task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", phase, what, got, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   typedef struct { bit ras, we, oe; bit [1:0] cas; int a; } smp_t;
   smp_t hist[$];
   int  m_mode, m_row, m_col, m_cnt;
   bit [1:0] m_oe, m_we;

   function automatic smp_t idle_smp();
      smp_t x; x.ras = 0; x.we = 0; x.oe = 0; x.cas = 0; x.a = 0; return x;
   endfunction

   always @(posedge clk) begin
      smp_t cur, old, now;
      int nm;
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i < S + 2; i++) hist.push_back(idle_smp());
         m_mode = 0; m_row = 0; m_col = 0; m_cnt = 0; m_oe = 0; m_we = 0;
      end else begin
         now.ras = !ras_n; now.we = !we_n; now.oe = !oe_n; now.cas = ~cas_n; now.a = int'(addr);
         hist.push_front(now);
         void'(hist.pop_back());
         cur = hist[S]; old = hist[S+1];
         nm = m_mode;
         if (!cur.ras && cur.cas == 0) nm = 0;
         else if (cur.ras && !old.ras) begin
            if (cur.cas != 0) begin
               nm = (m_mode == 1 || m_mode == 6) ? 6 : 5;
               m_row = m_cnt; m_cnt = (m_cnt + 1) % (1 << AW);
            end else begin
               nm = 4; m_row = cur.a;
            end
         end else if (cur.cas != 0 && old.cas == 0 && cur.ras && m_mode >= 1 && m_mode <= 4) begin
            m_col = cur.a; nm = cur.we ? 2 : 1;
         end else if (cur.we && !old.we && cur.ras && cur.cas != 0 && m_mode == 1)
            nm = 3;
         m_mode = nm;
         for (int i = 0; i < 2; i++) begin
            m_oe[i] = (nm == 1 || nm == 6) && cur.cas[i] && cur.oe && !cur.we;
            m_we[i] = (nm == 2 || nm == 3) && cur.cas[i] && cur.ras && cur.we;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && hist.size() != 0) begin
         chk("model cyc_type R11", 32'(cyc_type), 32'(m_mode));
         chk("model lane_oe", 32'(lane_oe), 32'(m_oe));
         chk("model lane_we", 32'(lane_we), 32'(m_we));
         chk("model row_addr", 32'(row_addr), 32'(m_row));
         chk("model col_addr", 32'(col_addr), 32'(m_col));
         for (int i = 0; i < 2; i++)
            if (lane_we[i]) mem[{row_addr[3:0], col_addr[3:0]}][8*i +: 8] = wdata[8*i +: 8];
      end
   end

   function automatic logic [15:0] rd_word();
      logic [15:0] v = mem[{row_addr[3:0], col_addr[3:0]}];
      return {lane_oe[1] ? v[15:8] : 8'h00, lane_oe[0] ? v[7:0] : 8'h00};
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic all_high();
      ras_n = 1; cas_n = 2'b11; we_n = 1; oe_n = 1;
      tick(5);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      tick(3);
      phase = "R1";
      chk("reset cyc_type R1", 32'(cyc_type), 0);
      chk("reset lanes R1", 32'({lane_oe, lane_we}), 0);
      chk("reset rows R1", 32'({row_addr, col_addr}), 0);
      rst_n = 1;
      tick(4);
      chk("after reset R1", 32'(cyc_type), 0);

      // R7 + R11: row-only refresh and its latency
      phase = "R7";
      addr = 10'h2A3; ras_n = 0;
      tick(1); chk("latency edge1 R11", 32'(cyc_type), 0);
      tick(1); chk("latency edge2 R11", 32'(cyc_type), 0);
      tick(1); chk("latency edge3 R11", 32'(cyc_type), 4);
      tick(2);
      chk("rowref row R7", 32'(row_addr), 32'h2A3);
      chk("rowref quiet R7", 32'({lane_oe, lane_we}), 0);
      all_high();
      chk("standby R10", 32'(cyc_type), 0);

      // R5: early write lower byte, then upper byte in page mode
      phase = "R5";
      addr = 10'h013; ras_n = 0; tick(2);
      addr = 10'h005; we_n = 0; wdata = 16'h77A5; tick(1);
      cas_n = 2'b10; tick(5);
      chk("early write type R5", 32'(cyc_type), 2);
      chk("write lower lane R5", 32'(lane_we), 2'b01);
      chk("write col R3", 32'(col_addr), 5);
      cas_n = 2'b11; tick(3);
      wdata = 16'h3C99; cas_n = 2'b01; tick(5);
      chk("write upper lane R5", 32'(lane_we), 2'b10);
      all_high();

      // R4: word read back of merged bytes
      phase = "R4";
      addr = 10'h013; ras_n = 0; tick(2);
      addr = 10'h005; cas_n = 2'b00; tick(4);
      chk("read type R4", 32'(cyc_type), 1);
      chk("oe held off until oe_n R4", 32'(lane_oe), 0);
      oe_n = 0; tick(4);
      chk("word read lanes R4", 32'(lane_oe), 2'b11);
      chk("read data R4", 32'(rd_word()), 32'h3CA5);
      all_high();

      // R2: first lane strobe latches column; second does not reload
      phase = "R2";
      addr = 10'h040; ras_n = 0; tick(2);
      addr = 10'h0A1; cas_n = 2'b10; oe_n = 0; tick(2);
      addr = 10'h1FF; cas_n = 2'b00; tick(5);
      chk("first strobe col R2", 32'(col_addr), 32'h0A1);
      chk("both lanes R2", 32'(lane_oe), 2'b11);
      cas_n = 2'b01; ras_n = 1; tick(5);
      chk("still active R2", 32'(cyc_type), 1);
      chk("upper lane only R2", 32'(lane_oe), 2'b10);
      all_high();
      chk("last strobe ends R10", 32'(cyc_type), 0);

      // R10: column strobe alone with row strobe high starts nothing
      phase = "R10";
      addr = 10'h0F0; cas_n = 2'b00; oe_n = 0; tick(5);
      chk("no access R10", 32'({cyc_type, lane_oe, lane_we}), 0);
      all_high();

      // R6: read-write
      phase = "R6";
      addr = 10'h011; ras_n = 0; tick(2);
      addr = 10'h002; cas_n = 2'b00; oe_n = 0; tick(5);
      oe_n = 1; we_n = 0; wdata = 16'hBEEF; tick(5);
      chk("rmw type R6", 32'(cyc_type), 3);
      chk("rmw lanes R6", 32'({lane_oe, lane_we}), 4'b0011);
      all_high();

      // R8: column-before-row refresh, address ignored, counter steps
      phase = "R8";
      addr = 10'h3FF; cas_n = 2'b01; tick(2); ras_n = 0; tick(5);
      chk("cbr type R8", 32'(cyc_type), 5);
      chk("cbr row from counter R8", 32'(row_addr), 0);
      chk("cbr quiet R8", 32'({lane_oe, lane_we}), 0);
      all_high();
      addr = 10'h155; cas_n = 2'b10; oe_n = 0; tick(2); ras_n = 0; tick(5);
      chk("cbr second row R8", 32'(row_addr), 1);
      chk("cbr drive off R8", 32'(lane_oe), 0);
      all_high();

      // R9: hidden refresh after a read
      phase = "R9";
      addr = 10'h013; ras_n = 0; tick(2);
      addr = 10'h005; cas_n = 2'b00; oe_n = 0; tick(5);
      ras_n = 1; tick(4);
      chk("read held R9", 32'(lane_oe), 2'b11);
      addr = 10'h222; ras_n = 0; tick(5);
      chk("hidden type R9", 32'(cyc_type), 6);
      chk("hidden row R9", 32'(row_addr), 2);
      chk("hidden keeps drive R9", 32'(lane_oe), 2'b11);
      chk("hidden col R9", 32'(col_addr), 5);
      all_high();

      phase = "R10";
      chk("final standby R10", 32'({cyc_type, lane_oe, lane_we}), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule